// File: doc/BRIEF.md
# Script Register-Operation Execution Unit

This unit carries out a single register-operation instruction on behalf of a small scripted I/O sequencer. A 32-bit instruction word arrives over a valid/ready handshake. The unit takes one operand from an external 128-entry byte register file or from an internal 8-bit accumulator. It combines that operand with either an immediate byte or the accumulator, using one of eight operators. The result goes either to the accumulator or back into the register file. A carry flag is kept for the shift and add operators.

Bits 31:27 of the instruction select the routing class. Bits 26:24 select the operator. When bit 23 is set, the accumulator replaces the immediate as the second operand. Bits 22:16 hold the register address and bits 15:8 hold the immediate. Bits 7:0 are not used. The register file read is combinational within the accept cycle. The write, the `done_o` pulse and any accumulator or carry update all appear one cycle later. An instruction word outside the three classes is reported as illegal and changes nothing.

Top module: `regop_exec`

## Requirements
- R1: After reset the outputs are: `acc_o`=0, `carry_o`=0, `done_o`=0, `illegal_o`=0, `rf_we_o`=0 and `instr_ready_o`=1.
- R2: When bits 31:27 = 5'b01101 (top byte 0x68 to 0x6F), the result of accumulator op data is written to register `addr`, and the accumulator is left unchanged.
- R3: When bits 31:27 = 5'b01110 (0x70 to 0x77), the result of register[`addr`] op data is placed in the accumulator, and no register-file write takes place. If no instruction is accepted, the accumulator and carry do not change.
- R4: When bits 31:27 = 5'b01111 (0x78 to 0x7F), the result of register[`addr`] op data is written back to register[`addr`].
- R5: When bit 23 = 1, the data operand is the accumulator and the immediate in bits 15:8 has no effect. When bit 23 = 0, the data operand is the immediate.
- R6: The operator codes in bits 26:24 are 0 for load (result = data), 2 for OR, 3 for XOR and 4 for AND. None of these four changes the carry flag. An OR with zero copies a register or the accumulator.
- R7: Code 6 (add) sets the carry to the carry out of bit 7. Code 7 (add with carry) also adds the old carry into the sum and sets the carry the same way.
- R8: Code 1 shifts left: bit 7 goes into carry and the old carry fills bit 0. Code 5 shifts right: bit 0 goes into carry and the old carry fills bit 7.
- R9: `done_o`, the write strobe and the new accumulator and carry values all appear in the cycle after the accept cycle. `done_o` lasts exactly one cycle, and `instr_ready_o` is low during that cycle.
- R10: An instruction word with any other value in bits 31:27 pulses `illegal_o` together with `done_o`. It does not write the register file and does not change the accumulator or the carry.
- R11: `rf_raddr_o` is bits 22:16 of the presented instruction. A write goes to that same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_i | input | 32 | Instruction word |
| instr_ready_o | output | 1 | Unit can accept an instruction |
| rf_raddr_o | output | 7 | Register-file read address |
| rf_rdata_i | input | 8 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 7 | Register-file write address |
| rf_wdata_o | output | 8 | Register-file write data |
| acc_o | output | 8 | Accumulator value |
| carry_o | output | 1 | Carry flag |
| done_o | output | 1 | Instruction completed (one cycle) |
| illegal_o | output | 1 | Unsupported instruction class (one cycle) |

## Verification
The three routing classes are exercised with register and accumulator contents chosen so that each class writes a different value to a different place. This exposes any swap of source or destination. The bit-23 operand select is run with an all-ones immediate against an accumulator that differs from it, so a wrong data path gives a visibly different AND result. The adds are run both with and without a carry out of bit 7, and add-with-carry is run with the old carry set, so the carry-in path is separated from the carry-out path. Shifts are run in both directions with the old carry both set and clear. An out-of-class instruction word and back-to-back issue check the no-write behaviour and the one-cycle busy window.

// File: rtl/regop_pkg.sv
package regop_pkg;
  parameter int unsigned DW = 8;
  parameter int unsigned AW = 7;
  parameter int unsigned IW = 32;

  localparam int unsigned IMM_LSB  = 8;
  localparam int unsigned ADDR_LSB = 16;
  localparam int unsigned SEL_BIT  = 23;
  localparam int unsigned OP_LSB   = 24;
  localparam int unsigned CLS_LSB  = 27;
  localparam int unsigned CLS_W    = IW - CLS_LSB;

  localparam logic [CLS_W-1:0] CLS_ACC2REG = 5'b01101;
  localparam logic [CLS_W-1:0] CLS_REG2ACC = 5'b01110;
  localparam logic [CLS_W-1:0] CLS_REG2REG = 5'b01111;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_SHL  = 3'd1,
    OP_OR   = 3'd2,
    OP_XOR  = 3'd3,
    OP_AND  = 3'd4,
    OP_SHR  = 3'd5,
    OP_ADD  = 3'd6,
    OP_ADDC = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    RT_ACC2REG,
    RT_REG2ACC,
    RT_REG2REG,
    RT_NONE
  } route_e;

  typedef struct packed {
    logic            legal;
    route_e          route;
    alu_op_e         op;
    logic            use_acc;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   imm;
  } dec_t;
endpackage

// File: rtl/regop_decode.sv
module regop_decode
  import regop_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  logic [CLS_W-1:0] cls;
  logic [7:0]       unused_low;

  assign cls        = instr_i[IW-1:CLS_LSB];
  assign unused_low = instr_i[IMM_LSB-1:0];

  always_comb begin
    dec_o.legal   = 1'b1;
    dec_o.route   = RT_NONE;
    unique case (cls)
      CLS_ACC2REG: dec_o.route = RT_ACC2REG;
      CLS_REG2ACC: dec_o.route = RT_REG2ACC;
      CLS_REG2REG: dec_o.route = RT_REG2REG;
      default:     dec_o.legal = 1'b0;
    endcase
    dec_o.op      = alu_op_e'(instr_i[OP_LSB +: 3]);
    dec_o.use_acc = instr_i[SEL_BIT];
    dec_o.addr    = instr_i[ADDR_LSB +: AW];
    dec_o.imm     = instr_i[IMM_LSB +: DW];
  end
endmodule

// File: rtl/regop_alu.sv
module regop_alu
  import regop_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] d_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         c_upd_o
);
  logic         cin_add;
  logic [W:0]   sum;

  assign cin_add = (op_i == OP_ADDC) & c_i;
  assign sum     = {1'b0, a_i} + {1'b0, d_i} + {{W{1'b0}}, cin_add};

  always_comb begin
    res_o   = d_i;
    c_o     = c_i;
    c_upd_o = 1'b0;
    unique case (op_i)
      OP_LOAD: res_o = d_i;
      OP_OR:   res_o = a_i | d_i;
      OP_XOR:  res_o = a_i ^ d_i;
      OP_AND:  res_o = a_i & d_i;
      OP_SHL: begin
        res_o   = {a_i[W-2:0], c_i};
        c_o     = a_i[W-1];
        c_upd_o = 1'b1;
      end
      OP_SHR: begin
        res_o   = {c_i, a_i[W-1:1]};
        c_o     = a_i[0];
        c_upd_o = 1'b1;
      end
      OP_ADD, OP_ADDC: begin
        res_o   = sum[W-1:0];
        c_o     = sum[W];
        c_upd_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regop_exec.sv
module regop_exec
  import regop_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic [31:0]   instr_i,
  output logic          instr_ready_o,
  output logic [6:0]    rf_raddr_o,
  input  logic [7:0]    rf_rdata_i,
  output logic          rf_we_o,
  output logic [6:0]    rf_waddr_o,
  output logic [7:0]    rf_wdata_o,
  output logic [7:0]    acc_o,
  output logic          carry_o,
  output logic          done_o,
  output logic          illegal_o
);
  dec_t          dec;
  logic          accept;
  logic [DW-1:0] a_opnd, d_opnd, res;
  logic          c_new, c_upd;

  logic          busy_q, we_q, ill_q, carry_q;
  logic [AW-1:0] waddr_q;
  logic [DW-1:0] wdata_q, acc_q;

  regop_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  assign accept     = instr_valid_i & ~busy_q;
  assign rf_raddr_o = dec.addr;
  assign a_opnd     = (dec.route == RT_ACC2REG) ? acc_q : rf_rdata_i;
  assign d_opnd     = dec.use_acc ? acc_q : dec.imm;

  regop_alu #(.W(DW)) u_alu (
    .op_i   (dec.op),
    .a_i    (a_opnd),
    .d_i    (d_opnd),
    .c_i    (carry_q),
    .res_o  (res),
    .c_o    (c_new),
    .c_upd_o(c_upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      ill_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      busy_q <= accept;
      ill_q  <= accept & ~dec.legal;
      we_q   <= accept & dec.legal & (dec.route != RT_REG2ACC);
      if (accept) begin
        waddr_q <= dec.addr;
        wdata_q <= res;
      end
      if (accept && dec.legal) begin
        if (dec.route == RT_REG2ACC) acc_q <= res;
        if (c_upd) carry_q <= c_new;
      end
    end
  end

  assign instr_ready_o = ~busy_q;
  assign done_o        = busy_q;
  assign illegal_o     = ill_q;
  assign rf_we_o       = we_q;
  assign rf_waddr_o    = waddr_q;
  assign rf_wdata_o    = wdata_q;
  assign acc_o         = acc_q;
  assign carry_o       = carry_q;
endmodule

// File: rtl/regop_chk.sv
module regop_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        instr_valid_i,
  input logic [31:0] instr_i,
  input logic        instr_ready_o,
  input logic [6:0]  rf_raddr_o,
  input logic [7:0]  rf_rdata_i,
  input logic        rf_we_o,
  input logic [6:0]  rf_waddr_o,
  input logic [7:0]  rf_wdata_o,
  input logic [7:0]  acc_o,
  input logic        carry_o,
  input logic        done_o,
  input logic        illegal_o
);
  logic acc_in, legal_in, logic_op, unused_chk;
  assign acc_in     = instr_valid_i & instr_ready_o;
  assign legal_in   = (instr_i[31:27] == 5'b01101) | (instr_i[31:27] == 5'b01110) |
                      (instr_i[31:27] == 5'b01111);
  assign logic_op   = (instr_i[26:24] == 3'd0) | (instr_i[26:24] == 3'd2) |
                      (instr_i[26:24] == 3'd3) | (instr_i[26:24] == 3'd4);
  assign unused_chk = ^{rf_raddr_o, rf_rdata_i, rf_wdata_o};

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_in |=> done_o); // R9
  AST_DONE_NEEDS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_in |=> !done_o); // R9
  AST_BUSY_WHILE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !instr_ready_o); // R9
  AST_WRITE_NOT_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (done_o && !illegal_o)); // R10
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_in && !legal_in) |=> (illegal_o && !rf_we_o && $stable(acc_o) && $stable(carry_o))); // R10
  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_in && logic_op) |=> $stable(carry_o)); // R6
  AST_IDLE_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_in |=> ($stable(acc_o) && $stable(carry_o))); // R3
  AST_WADDR_FROM_INSTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_in |=> (!rf_we_o || rf_waddr_o == $past(instr_i[22:16]))); // R11
  AST_REG2ACC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_in && instr_i[31:27] == 5'b01110) |=> !rf_we_o); // R3
endmodule

bind regop_exec regop_chk u_chk (.*);

// File: tb/regop_exec_tb.sv
module regop_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        instr_ready;
  logic [6:0]  rf_raddr, rf_waddr;
  logic [7:0]  rf_rdata, rf_wdata;
  logic        rf_we;
  logic [7:0]  acc;
  logic        carry, done, illegal;

  logic [7:0]  mem [128];
  int          total = 0, bad = 0;
  logic [7:0]  m_acc = '0;
  logic        m_c = 1'b0;
  bit          finished = 0;

  always #10 clk = ~clk;

  regop_exec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .instr_ready_o(instr_ready), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .acc_o(acc), .carry_o(carry), .done_o(done), .illegal_o(illegal)
  );

  assign rf_rdata = mem[rf_raddr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 3 + 1);
    end else if (rf_we) begin
      mem[rf_waddr] <= rf_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] cls, input logic [2:0] op,
                                     input logic sel, input logic [6:0] a, input logic [7:0] imm);
    return {cls, op, sel, a, imm, 8'h00};
  endfunction

  // reference: returns {carry, result}
  function automatic logic [8:0] ref_alu(input logic [2:0] op, input logic [7:0] a,
                                         input logic [7:0] d, input logic c);
    logic [8:0] s;
    case (op)
      3'd0: return {c, d};
      3'd1: return {a[7], a[6:0], c};
      3'd2: return {c, a | d};
      3'd3: return {c, a ^ d};
      3'd4: return {c, a & d};
      3'd5: return {a[0], c, a[7:1]};
      3'd6: begin s = {1'b0, a} + {1'b0, d}; return s; end
      default: begin s = {1'b0, a} + {1'b0, d} + {8'd0, c}; return s; end
    endcase
  endfunction

  task automatic run(input logic [31:0] w, input string req);
    logic [4:0] cls; logic [2:0] op; logic [6:0] a; logic [7:0] av, dv;
    logic [8:0] r; logic legal; logic exp_we; logic [7:0] exp_acc;
    cls = w[31:27]; op = w[26:24]; a = w[22:16];
    legal = (cls == 5'b01101) || (cls == 5'b01110) || (cls == 5'b01111);
    av = (cls == 5'b01101) ? m_acc : mem[a];
    dv = w[23] ? m_acc : w[15:8];
    r = ref_alu(op, av, dv, m_c);
    exp_we = legal && (cls != 5'b01110);
    exp_acc = (legal && cls == 5'b01110) ? r[7:0] : m_acc;
    @(negedge clk);
    chk(instr_ready == 1'b1, {req, " ready before issue (R9)"}, instr_ready, 1);
    instr = w; instr_valid = 1'b1;
    #1 chk(rf_raddr == a, {req, " R11 read addr"}, rf_raddr, a);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(done == 1'b1, {req, " R9 done"}, done, 1);
    chk(instr_ready == 1'b0, {req, " R9 ready low"}, instr_ready, 0);
    chk(illegal == !legal, {req, " R10 illegal"}, illegal, !legal);
    chk(rf_we == exp_we, {req, " write strobe"}, rf_we, exp_we);
    if (exp_we) begin
      chk(rf_waddr == a, {req, " R11 write addr"}, rf_waddr, a);
      chk(rf_wdata == r[7:0], {req, " write data"}, rf_wdata, r[7:0]);
    end
    chk(acc == exp_acc, {req, " acc"}, acc, exp_acc);
    if (legal) m_c = r[8];
    chk(carry == m_c, {req, " carry"}, carry, m_c);
    m_acc = exp_acc;
    @(negedge clk);
    chk(done == 1'b0, {req, " R9 done one cycle"}, done, 0);
    if (exp_we) chk(mem[a] == r[7:0], {req, " rf updated"}, mem[a], r[7:0]);
  endtask

  task automatic t_reset();
    chk(acc == 8'h00, "R1 acc", acc, 0);
    chk(carry == 1'b0, "R1 carry", carry, 0);
    chk(done == 1'b0 && illegal == 1'b0, "R1 done/illegal", {done, illegal}, 0);
    chk(rf_we == 1'b0, "R1 we", rf_we, 0);
    chk(instr_ready == 1'b1, "R1 ready", instr_ready, 1);
  endtask

  task automatic t_moves();
    run(mk(5'b01110, 3'd2, 1'b0, 7'd5, 8'h00), "R3 R6 reg5 to acc");
    chk(acc == 8'd16, "R3 acc literal", acc, 16);
    run(mk(5'b01101, 3'd2, 1'b0, 7'd9, 8'h00), "R2 acc to reg9");
    chk(mem[9] == 8'd16, "R2 reg9 literal", mem[9], 16);
    run(mk(5'b01110, 3'd0, 1'b0, 7'd3, 8'hA5), "R6 R3 load imm to acc");
  endtask

  task automatic t_logic();
    run(mk(5'b01111, 3'd3, 1'b0, 7'd20, 8'h3C), "R4 R6 xor reg20");
    run(mk(5'b01101, 3'd4, 1'b0, 7'd21, 8'h0F), "R2 R6 and acc into reg21");
    run(mk(5'b01111, 3'd2, 1'b0, 7'd22, 8'h80), "R4 R6 or reg22");
  endtask

  task automatic t_sel();
    run(mk(5'b01110, 3'd0, 1'b0, 7'd0, 8'h5A), "R5 set acc");
    run(mk(5'b01111, 3'd4, 1'b1, 7'd40, 8'hFF), "R5 and with acc operand");
    chk(mem[40] == (8'd121 & 8'h5A), "R5 literal", mem[40], 8'd121 & 8'h5A);
    run(mk(5'b01110, 3'd2, 1'b1, 7'd41, 8'hFF), "R5 or reg with acc");
  endtask

  task automatic t_add();
    run(mk(5'b01110, 3'd6, 1'b0, 7'd30, 8'hC0), "R7 add carry out");
    chk(acc == 8'h1B && carry == 1'b1, "R7 add literal", {carry, acc}, 9'h11B);
    run(mk(5'b01111, 3'd7, 1'b0, 7'd31, 8'h01), "R7 addc carry in");
    chk(mem[31] == 8'h60 && carry == 1'b0, "R7 addc literal", {carry, mem[31]}, 9'h060);
    run(mk(5'b01111, 3'd7, 1'b0, 7'd31, 8'hA0), "R7 addc no carry in");
    run(mk(5'b01110, 3'd6, 1'b0, 7'd85, 8'hFF), "R7 add wrap");
  endtask

  task automatic t_shift();
    run(mk(5'b01110, 3'd0, 1'b0, 7'd0, 8'h81), "R8 set acc");
    run(mk(5'b01101, 3'd1, 1'b0, 7'd50, 8'h00), "R8 shl acc into reg50");
    run(mk(5'b01101, 3'd1, 1'b0, 7'd51, 8'h00), "R8 shl again");
    run(mk(5'b01111, 3'd5, 1'b0, 7'd52, 8'h00), "R8 shr reg52");
    run(mk(5'b01111, 3'd5, 1'b0, 7'd53, 8'h00), "R8 shr reg53");
    run(mk(5'b01110, 3'd5, 1'b0, 7'd7, 8'h00), "R8 shr into acc");
  endtask

  task automatic t_illegal();
    logic [7:0] a0; logic c0;
    a0 = acc; c0 = carry;
    run(32'h8008_1200, "R10 illegal 0x80");
    run(32'h6005_3300, "R10 illegal 0x60");
    chk(acc == a0 && carry == c0, "R10 state kept", {carry, acc}, {c0, a0});
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_moves();
    t_logic();
    t_sel();
    t_add();
    t_shift();
    t_illegal();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule